// File: doc/BRIEF.md
# 64-Source Prioritised Interrupt Controller

This block collects 64 level-sensitive interrupt lines and turns them into two requests for a processor: a normal request and a fast request. Each source has an enable bit and a type bit that routes it to one of the two requests. Each normal source also has a 4-bit priority. Software reaches every piece of state through a 4 KB window on a simple 32-bit bus. A word index, taken from address bits [11:2], picks the register.

Several registers are more than plain storage. Single enable bits can be set or cleared by writing a source number. Software can overwrite the pending vector directly to raise or drop interrupts. Two vector status words report the winning normal source (with its priority) and the lowest-numbered fast source. Reading either vector word acknowledges the source it returns by clearing that source's pending bit. The normal request is gated by a mask level: only sources whose priority is above the mask raise it, and the all-ones mask value lets every enabled normal source through.

Top module: `vic64_ctrl`

## Requirements
- R1: After reset, the following are all zero: pending, enable, type, control, mask and the eight priority words. Both request outputs are low, and reads of those registers return zero.
- R2: A rising input level sets that source's pending bit and a falling level clears it. The new value is visible one clock later in the source status words: word 18 holds sources 63..32 and word 19 holds sources 31..0.
- R3: Writing N to word 2 sets enable bit N and writing N to word 3 clears it. Only write-data bits [5:0] are used. Both words read back as zero.
- R4: Writes to the high half (words 4, 6, 20) or the low half (words 5, 7, 21) of the enable, type and force vectors replace only that half. A force write replaces the pending bits directly. The force words read back as zero.
- R5: A write to the mask (word 1) keeps only bits [4:0].
- R6: A control write (word 0) keeps only bits 25, 24, 22, 21, 20, 19 and 18. When bit 24 is set in the written value, a 1 written to bit 25 clears bit 25 instead of setting it.
- R7: Priority word k (word index 8..15) holds the 4-bit priorities of sources 8*(15-k) to 8*(15-k)+7. Source s uses bits [4*(s%8)+3 : 4*(s%8)].
- R8: A source is a fast source when its type bit is 1. The fast request is high exactly when some source is pending, enabled and fast. Words 24/25 read the fast-pending vector (high/low) and words 22/23 read the normal-pending vector.
- R9: The normal request is high when some pending, enabled normal source has a priority strictly greater than the mask. With the mask at 31 it is high whenever any pending, enabled normal source exists.
- R10: A read of word 16 returns (source << 16) | priority for the highest-priority pending, enabled normal source, with ties going to the highest source number. The read clears that source's pending bit. It returns all ones when there is no such source.
- R11: A read of word 17 returns the number of the lowest-numbered pending, enabled fast source and clears its pending bit. It returns all ones when there is none.
- R12: The following writes change no state: writes to words 16, 17, 18, 19, 22, 23, 24, 25, writes to byte offsets 0x100..0x2FC, and writes to unmapped offsets. Unmapped offsets read as zero.
- R13: When an input edge and a force write touch the same pending half in one cycle, the force value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Interrupt source levels |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Word address, byte-address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during the access cycle |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with the package defaults: 64 sources, 4-bit priorities and eight priority words. With these values every word of the map is reachable. They also bring in source 63 in the last priority nibble, the high halves of every split vector, and the six-bit source number that the enable-by-number registers truncate to. Directed scenarios use both the input pins and force writes to create pending sources. They then drain the sources through vector reads to check the acknowledge order, the tie-break and the all-ones empty response.

// File: rtl/vic64_pkg.sv
package vic64_pkg;

    localparam int NSRC         = 64;
    localparam int SRC_IDX_W    = $clog2(NSRC);
    localparam int DATA_W       = 32;
    localparam int HALF_W       = NSRC / 2;
    localparam int PRIO_W       = 4;
    localparam int SRC_PER_WORD = DATA_W / PRIO_W;
    localparam int NPRIO_WORDS  = NSRC / SRC_PER_WORD;
    localparam int MASK_W       = 5;
    localparam int WIDX_W       = 10;
    localparam int PRIO_BASE    = 8;
    localparam int VEC_FIRST    = 'h100 / 4;
    localparam int VEC_LAST     = 'h2FC / 4;

    // control bit positions
    localparam int CB_ABT_FLAG = 25;
    localparam int CB_ABT_EN   = 24;
    localparam int CB_NDIS     = 22;
    localparam int CB_FDIS     = 21;
    localparam int CB_NBIAS    = 20;
    localparam int CB_FBIAS    = 19;
    localparam int CB_NMODE    = 18;
    localparam logic [DATA_W-1:0] CTL_KEEP =
        (DATA_W'(1) << CB_ABT_FLAG) | (DATA_W'(1) << CB_ABT_EN) |
        (DATA_W'(1) << CB_NDIS)     | (DATA_W'(1) << CB_FDIS)   |
        (DATA_W'(1) << CB_NBIAS)    | (DATA_W'(1) << CB_FBIAS)  |
        (DATA_W'(1) << CB_NMODE);

    typedef enum logic [WIDX_W-1:0] {
        W_CTL    = 10'd0,
        W_NMASK  = 10'd1,
        W_ENNUM  = 10'd2,
        W_DISNUM = 10'd3,
        W_ENH    = 10'd4,
        W_ENL    = 10'd5,
        W_TYH    = 10'd6,
        W_TYL    = 10'd7,
        W_NVEC   = 10'd16,
        W_FVEC   = 10'd17,
        W_SRCH   = 10'd18,
        W_SRCL   = 10'd19,
        W_FRCH   = 10'd20,
        W_FRCL   = 10'd21,
        W_NPH    = 10'd22,
        W_NPL    = 10'd23,
        W_FPH    = 10'd24,
        W_FPL    = 10'd25
    } word_e;

    typedef logic [NPRIO_WORDS-1:0][DATA_W-1:0] prio_arr_t;

    typedef struct packed {
        logic                 valid;
        logic [SRC_IDX_W-1:0] src;
        logic [PRIO_W-1:0]    prio;
    } nvec_t;

    typedef struct packed {
        logic                 valid;
        logic [SRC_IDX_W-1:0] src;
    } fvec_t;

    function automatic logic [PRIO_W-1:0] prio_of(prio_arr_t w, int s);
        return w[s / SRC_PER_WORD][(s % SRC_PER_WORD) * PRIO_W +: PRIO_W];
    endfunction

endpackage

// File: rtl/vic64_src_track.sv
module vic64_src_track
    import vic64_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_in,
    input  logic                 frc_hi_we,
    input  logic                 frc_lo_we,
    input  logic [HALF_W-1:0]    frc_data,
    input  logic                 ack_en,
    input  logic [SRC_IDX_W-1:0] ack_idx,
    output logic [NSRC-1:0]      pend,
    output logic [NSRC-1:0]      seen
);

    logic [NSRC-1:0] pend_nxt;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] fall;

    assign rise = src_in & ~seen;
    assign fall = ~src_in & seen;

    always_comb begin
        pend_nxt = (pend | rise) & ~fall;
        if (frc_hi_we) pend_nxt[NSRC-1:HALF_W] = frc_data;
        if (frc_lo_we) pend_nxt[HALF_W-1:0]    = frc_data;
        if (ack_en)    pend_nxt[ack_idx]       = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            seen <= '0;
        end else begin
            pend <= pend_nxt;
            seen <= src_in;
        end
    end

endmodule

// File: rtl/vic64_resolver.sv
module vic64_resolver
    import vic64_pkg::*;
(
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   en,
    input  logic [NSRC-1:0]   ty,
    input  prio_arr_t         prio,
    input  logic [MASK_W-1:0] nmask,
    output logic [NSRC-1:0]   nflag,
    output logic [NSRC-1:0]   fflag,
    output nvec_t             nvec,
    output fvec_t             fvec,
    output logic              nreq,
    output logic              freq
);

    logic              above;
    logic [PRIO_W-1:0] p;

    assign nflag = pend & en & ~ty;
    assign fflag = pend & en & ty;
    assign freq  = |fflag;

    always_comb begin
        nvec  = '0;
        above = 1'b0;
        p     = '0;
        for (int i = 0; i < NSRC; i++) begin
            p = prio_of(prio, i);
            if (nflag[i] && (!nvec.valid || p >= nvec.prio)) begin
                nvec.valid = 1'b1;
                nvec.src   = SRC_IDX_W'(i);
                nvec.prio  = p;
            end
            if (nflag[i] && (MASK_W'(p) > nmask)) above = 1'b1;
        end
    end

    always_comb begin
        fvec = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (fflag[i]) begin
                fvec.valid = 1'b1;
                fvec.src   = SRC_IDX_W'(i);
            end
        end
    end

    assign nreq = above | ((nmask == '1) && (|nflag));

endmodule

// File: rtl/vic64_ctrl.sv
module vic64_ctrl
    import vic64_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [WIDX_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nirq_o,
    output logic              firq_o
);

    word_e             widx;
    logic              wr;
    logic              rd;
    logic              in_vec_rgn;
    logic [DATA_W-1:0] ctl_q;
    logic [MASK_W-1:0] nmask_q;
    logic [NSRC-1:0]   en_q;
    logic [NSRC-1:0]   ty_q;
    prio_arr_t         prio_q;
    logic [NSRC-1:0]   pend_w;
    logic [NSRC-1:0]   seen_w;
    logic [NSRC-1:0]   nflag_w;
    logic [NSRC-1:0]   fflag_w;
    nvec_t             nvec_w;
    fvec_t             fvec_w;
    logic              nack;
    logic              fack;
    logic [DATA_W-1:0] ctl_nxt;

    assign widx       = word_e'(bus_addr);
    assign in_vec_rgn = (int'(bus_addr) >= VEC_FIRST) && (int'(bus_addr) <= VEC_LAST);
    assign wr         = bus_en && bus_we && !in_vec_rgn;
    assign rd         = bus_en && !bus_we;
    assign nack       = rd && (widx == W_NVEC) && nvec_w.valid;
    assign fack       = rd && (widx == W_FVEC) && fvec_w.valid;

    always_comb begin
        ctl_nxt = bus_wdata & CTL_KEEP;
        if (ctl_nxt[CB_ABT_EN] && bus_wdata[CB_ABT_FLAG])
            ctl_nxt[CB_ABT_FLAG] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            nmask_q <= '0;
            en_q    <= '0;
            ty_q    <= '0;
            prio_q  <= '0;
        end else if (wr) begin
            case (widx)
                W_CTL:    ctl_q <= ctl_nxt;
                W_NMASK:  nmask_q <= bus_wdata[MASK_W-1:0];
                W_ENNUM:  en_q[bus_wdata[SRC_IDX_W-1:0]] <= 1'b1;
                W_DISNUM: en_q[bus_wdata[SRC_IDX_W-1:0]] <= 1'b0;
                W_ENH:    en_q[NSRC-1:HALF_W] <= bus_wdata;
                W_ENL:    en_q[HALF_W-1:0]    <= bus_wdata;
                W_TYH:    ty_q[NSRC-1:HALF_W] <= bus_wdata;
                W_TYL:    ty_q[HALF_W-1:0]    <= bus_wdata;
                default: begin
                    for (int k = 0; k < NPRIO_WORDS; k++) begin
                        if (int'(bus_addr) == PRIO_BASE + NPRIO_WORDS - 1 - k)
                            prio_q[k] <= bus_wdata;
                    end
                end
            endcase
        end
    end

    vic64_src_track i_track (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .frc_hi_we (wr && (widx == W_FRCH)),
        .frc_lo_we (wr && (widx == W_FRCL)),
        .frc_data  (bus_wdata),
        .ack_en    (nack || fack),
        .ack_idx   (nack ? nvec_w.src : fvec_w.src),
        .pend      (pend_w),
        .seen      (seen_w)
    );

    vic64_resolver i_res (
        .pend  (pend_w),
        .en    (en_q),
        .ty    (ty_q),
        .prio  (prio_q),
        .nmask (nmask_q),
        .nflag (nflag_w),
        .fflag (fflag_w),
        .nvec  (nvec_w),
        .fvec  (fvec_w),
        .nreq  (nirq_o),
        .freq  (firq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (widx)
            W_CTL:   bus_rdata = ctl_q;
            W_NMASK: bus_rdata = DATA_W'(nmask_q);
            W_ENH:   bus_rdata = en_q[NSRC-1:HALF_W];
            W_ENL:   bus_rdata = en_q[HALF_W-1:0];
            W_TYH:   bus_rdata = ty_q[NSRC-1:HALF_W];
            W_TYL:   bus_rdata = ty_q[HALF_W-1:0];
            W_NVEC:  bus_rdata = nvec_w.valid ?
                                 {16'(nvec_w.src), 16'(nvec_w.prio)} : '1;
            W_FVEC:  bus_rdata = fvec_w.valid ? DATA_W'(fvec_w.src) : '1;
            W_SRCH:  bus_rdata = pend_w[NSRC-1:HALF_W];
            W_SRCL:  bus_rdata = pend_w[HALF_W-1:0];
            W_NPH:   bus_rdata = nflag_w[NSRC-1:HALF_W];
            W_NPL:   bus_rdata = nflag_w[HALF_W-1:0];
            W_FPH:   bus_rdata = fflag_w[NSRC-1:HALF_W];
            W_FPL:   bus_rdata = fflag_w[HALF_W-1:0];
            default: begin
                for (int k = 0; k < NPRIO_WORDS; k++) begin
                    if (int'(bus_addr) == PRIO_BASE + NPRIO_WORDS - 1 - k)
                        bus_rdata = prio_q[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/vic64_checker.sv
module vic64_checker
    import vic64_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_in,
    input logic              bus_en,
    input logic              bus_we,
    input logic [WIDX_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              nirq_o,
    input logic              firq_o,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   seen,
    input logic [NSRC-1:0]   en,
    input logic [NSRC-1:0]   ty,
    input logic [MASK_W-1:0] nmask
);

    a_r5_mask_low_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == 10'd1) |=> nmask == $past(bus_wdata[MASK_W-1:0]));

    a_r3_enable_by_number: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == 10'd2) |=> en[$past(bus_wdata[SRC_IDX_W-1:0])]);

    a_r3_disable_by_number: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == 10'd3) |=> !en[$past(bus_wdata[SRC_IDX_W-1:0])]);

    a_r2_level_follows_edge: assert property (@(posedge clk) disable iff (rst)
        !bus_en |=> ((pend ^ $past(src_in)) & $past(src_in ^ seen)) == '0);

    a_r10_normal_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr == 10'd16 && bus_rdata != '1)
        |=> !pend[$past(bus_rdata[16 +: SRC_IDX_W])]);

    a_r11_fast_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr == 10'd17 && bus_rdata != '1)
        |=> !pend[$past(bus_rdata[SRC_IDX_W-1:0])]);

    a_r8_fast_needs_source: assert property (@(posedge clk) disable iff (rst)
        firq_o |-> (pend & en & ty) != '0);

    a_r9_normal_needs_source: assert property (@(posedge clk) disable iff (rst)
        nirq_o |-> (pend & en & ~ty) != '0);

endmodule

bind vic64_ctrl vic64_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .src_in    (src_in),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .nirq_o    (nirq_o),
    .firq_o    (firq_o),
    .pend      (pend_w),
    .seen      (seen_w),
    .en        (en_q),
    .ty        (ty_q),
    .nmask     (nmask_q)
);

// File: tb/test_vic64_ctrl.sv
`timescale 1ns/1ps
module test_vic64_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_in = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nirq_o;
    logic        firq_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    vic64_ctrl i_vic64_ctrl (
        .clk(clk), .rst(rst), .src_in(src_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nirq_o(nirq_o), .firq_o(firq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] byte_addr, logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = byte_addr[11:2]; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] byte_addr, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = byte_addr[11:2];
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        src_in = '0;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 nirq", 32'(nirq_o), 0);
        check("R1 firq", 32'(firq_o), 0);
        rd(12'h000, rv); check("R1 ctl", rv, 0);
        rd(12'h004, rv); check("R1 mask", rv, 0);
        rd(12'h014, rv); check("R1 enable low", rv, 0);
        rd(12'h018, rv); check("R1 type high", rv, 0);
        rd(12'h03C, rv); check("R1 prio word 15", rv, 0);
        rd(12'h04C, rv); check("R1 source low", rv, 0);
    endtask

    task automatic t_mask_ctl();
        do_reset();
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, rv); check("R5 mask low bits", rv, 32'h1F);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, rv); check("R6 ctl keep, flag w1c", rv, 32'h017C_0000);
        wr(12'h000, 32'h0200_0000);
        rd(12'h000, rv); check("R6 flag set without enable", rv, 32'h0200_0000);
        wr(12'h000, 32'h0300_0000);
        rd(12'h000, rv); check("R6 flag cleared with enable", rv, 32'h0100_0000);
    endtask

    task automatic t_enable_num();
        do_reset();
        wr(12'h008, 32'h45);
        rd(12'h014, rv); check("R3 enable num low 6 bits", rv, 32'h20);
        wr(12'h008, 32'd40);
        rd(12'h010, rv); check("R3 enable num high", rv, 32'h100);
        rd(12'h008, rv); check("R3 enable num reads zero", rv, 0);
        wr(12'h00C, 32'd5);
        rd(12'h014, rv); check("R3 disable num", rv, 0);
        rd(12'h010, rv); check("R3 disable leaves others", rv, 32'h100);
    endtask

    task automatic t_halves();
        do_reset();
        wr(12'h014, 32'hA5A5_A5A5);
        wr(12'h010, 32'h1234_5678);
        wr(12'h014, 32'h0);
        rd(12'h010, rv); check("R4 enable high kept", rv, 32'h1234_5678);
        wr(12'h018, 32'hCAFE_0001);
        wr(12'h01C, 32'h0000_FFFF);
        rd(12'h018, rv); check("R4 type high kept", rv, 32'hCAFE_0001);
        rd(12'h01C, rv); check("R4 type low", rv, 32'h0000_FFFF);
        wr(12'h050, 32'hF000_0000);
        rd(12'h048, rv); check("R4 force high", rv, 32'hF000_0000);
        rd(12'h04C, rv); check("R4 force leaves low", rv, 0);
        rd(12'h050, rv); check("R4 force reads zero", rv, 0);
    endtask

    task automatic t_inputs();
        do_reset();
        src_in[40] = 1'b1; tick();
        rd(12'h048, rv); check("R2 rise sets pending", rv, 32'h100);
        src_in[40] = 1'b0; tick();
        rd(12'h048, rv); check("R2 fall clears pending", rv, 0);
        src_in[2] = 1'b1;
        wr(12'h054, 32'h0);
        rd(12'h04C, rv); check("R13 force wins over edge", rv, 0);
        src_in[2] = 1'b0; tick();
    endtask

    task automatic t_normal();
        do_reset();
        wr(12'h014, 32'hFF);
        wr(12'h03C, 32'h0000_3210);
        src_in[1] = 1'b1; src_in[3] = 1'b1; tick();
        check("R9 above mask 0", 32'(nirq_o), 1);
        check("R8 no fast", 32'(firq_o), 0);
        wr(12'h004, 32'd3);
        check("R9 none above mask 3", 32'(nirq_o), 0);
        wr(12'h004, 32'd31);
        check("R9 mask 31 passes all", 32'(nirq_o), 1);
        wr(12'h004, 32'd2);
        check("R9 prio 3 above mask 2", 32'(nirq_o), 1);
        rd(12'h05C, rv); check("R8 normal pending low", rv, 32'hA);
        rd(12'h040, rv); check("R10 vector highest prio", rv, 32'h0003_0003);
        rd(12'h04C, rv); check("R10 ack cleared src3", rv, 32'h2);
        rd(12'h040, rv); check("R10 vector next", rv, 32'h0001_0001);
        rd(12'h040, rv); check("R10 vector empty", rv, 32'hFFFF_FFFF);
        check("R9 low when drained", 32'(nirq_o), 0);
        src_in = '0; tick();
        wr(12'h03C, 32'h0505_0000);
        wr(12'h054, 32'h50);
        rd(12'h040, rv); check("R10 tie highest number", rv, 32'h0006_0005);
        rd(12'h040, rv); check("R10 tie second", rv, 32'h0004_0005);
        wr(12'h020, 32'h7000_0000);
        wr(12'h010, 32'h8000_0000);
        wr(12'h050, 32'h8000_0000);
        rd(12'h040, rv); check("R7 source 63 in word 8", rv, 32'h003F_0007);
    endtask

    task automatic t_fast();
        do_reset();
        wr(12'h01C, 32'h300);
        wr(12'h014, 32'h300);
        wr(12'h054, 32'h300);
        check("R8 fast request", 32'(firq_o), 1);
        check("R8 fast not normal", 32'(nirq_o), 0);
        rd(12'h064, rv); check("R8 fast pending low", rv, 32'h300);
        rd(12'h05C, rv); check("R8 normal pending low", rv, 0);
        rd(12'h040, rv); check("R10 no normal source", rv, 32'hFFFF_FFFF);
        rd(12'h044, rv); check("R11 lowest fast", rv, 32'd8);
        rd(12'h044, rv); check("R11 next fast", rv, 32'd9);
        rd(12'h044, rv); check("R11 fast empty", rv, 32'hFFFF_FFFF);
        check("R8 fast request dropped", 32'(firq_o), 0);
    endtask

    task automatic t_ignored();
        do_reset();
        wr(12'h004, 32'd7);
        wr(12'h014, 32'h1);
        wr(12'h054, 32'h1);
        wr(12'h048, 32'hFFFF_FFFF);
        wr(12'h04C, 32'h0);
        wr(12'h05C, 32'h0);
        wr(12'h064, 32'hFFFF_FFFF);
        wr(12'h040, 32'h0);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h2FC, 32'hFFFF_FFFF);
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h004, rv); check("R12 mask unchanged", rv, 32'd7);
        rd(12'h014, rv); check("R12 enable unchanged", rv, 32'h1);
        rd(12'h04C, rv); check("R12 pending low unchanged", rv, 32'h1);
        rd(12'h048, rv); check("R12 pending high unchanged", rv, 0);
        rd(12'h000, rv); check("R12 ctl unchanged", rv, 0);
        rd(12'h800, rv); check("R12 unmapped reads zero", rv, 0);
        rd(12'h100, rv); check("R12 vector region reads zero", rv, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mask_ctl();
        t_enable_num();
        t_halves();
        t_inputs();
        t_normal();
        t_fast();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule